// File: doc/BRIEF.md
# DFI Data-Enable Timing Generator

This block sits between a memory controller's command scheduler and a DFI-style PHY interface. Each time the scheduler issues a read or a write, it pulses a strobe and gives the burst length in interface cycles. The block then produces a read-data enable and a write-data enable. Each enable is raised after its own programmable latency and is held for exactly the burst length. When bursts are issued back to back, their windows merge into one enable with no gap between them.

Write data, the byte mask and an optional check code are pushed ahead of time into a small queue. A second programmable latency, counted from the rise of the write enable, sets when they leave the queue. Between data windows the data, mask and code outputs are held at zero. The latency settings are inputs, but the block only takes up a new value during a cycle when no command is being presented and no burst is pending.

Top module: `dfi_en_timer`

## Requirements
- R1: A read strobe sampled at clock edge c raises rddata_en_o in the cycle that follows edge c+L-1, where L is the captured read latency (L=1 means the cycle directly after the strobe's edge).
- R2: rddata_en_o stays high for exactly as many cycles as the read burst length given with the strobe.
- R3: A write strobe raises wrdata_en_o after the captured write latency, counted the same way as in R1, and holds it for exactly the write burst length.
- R4: Commands spaced exactly one burst length apart produce one continuous enable window with no gap. Overlapping windows are ORed together.
- R5: Queued write words appear on wrdata_o and wrdata_mask_o in push order, starting D cycles after wrdata_en_o rises (D is the captured data latency) and lasting one word per burst cycle. Outside that window both outputs are zero.
- R6: With a data latency of 0, the first word appears in the same cycle that wrdata_en_o rises.
- R7: wrdata_mask_o has ceil(DATA_W/8) bits. Bit n covers data byte n, and the top bit covers the partial top byte. The mask travels unchanged alongside its word; with DATA_W=36 the mask is 5 bits wide.
- R8: ecc_wrdata_en_o has the same timing as wrdata_en_o. ecc_wrdata_o carries each word's queued code with the same timing as wrdata_o.
- R9: A latency input is captured only in a cycle with no pending burst and no strobe. A change made while a burst is pending has no effect on commands issued during that time.
- R10: A strobe with a burst length of 0 produces no enable.
- R11: A captured read or write latency of 0 behaves as 1. Any latency above MAX_LAT behaves as MAX_LAT.
- R12: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_issue_i | input | 1 | Read command issued this cycle |
| rd_beats_i | input | LEN_W | Read burst length in interface cycles |
| wr_issue_i | input | 1 | Write command issued this cycle |
| wr_beats_i | input | LEN_W | Write burst length in interface cycles |
| wq_push_i | input | 1 | Push one word into the write queue |
| wq_data_i | input | DATA_W | Write data word |
| wq_mask_i | input | MASK_W | Byte mask for the word |
| wq_ecc_i | input | ECC_W | Check code for the word |
| cfg_rd_lat_i | input | LAT_W | Read enable latency |
| cfg_wr_lat_i | input | LAT_W | Write enable latency |
| cfg_wd_lat_i | input | LAT_W | Data latency after write enable |
| rddata_en_o | output | 1 | Read data enable |
| wrdata_en_o | output | 1 | Write data enable |
| wrdata_o | output | DATA_W | Write data |
| wrdata_mask_o | output | MASK_W | Write byte mask |
| ecc_wrdata_en_o | output | 1 | Check-code enable |
| ecc_wrdata_o | output | ECC_W | Write check code |

## Verification
The hardest case to reach is a latency change that arrives while a burst is still pending, followed by a second command issued inside that same window. The bench starts a read burst and alters the read latency input one cycle later. It then issues a second read exactly one burst length after the first. It checks that the enable forms one unbroken window at the old timing, and that the new latency only applies after the block has gone idle. Merged back-to-back windows and a zero data latency are reached with similar directed sequences.

// File: rtl/dfi_en_pkg.sv
package dfi_en_pkg;

   // Saturate a programmed latency into the supported range.
   function automatic int unsigned lat_clamp(int unsigned v, int unsigned lo, int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int unsigned mask_bits(int unsigned data_w);
      return (data_w + 7) / 8;
   endfunction

endpackage

// File: rtl/dfi_en_window.sv
// Shift vector producing a delayed enable window; windows from successive
// commands OR into the vector so adjacent bursts merge.
module dfi_en_window #(
   parameter int DEPTH = 32,
   parameter int LAT_W = 5,
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [LAT_W-1:0] lat,
   input  logic [LEN_W-1:0] len,
   output logic             en,
   output logic             busy
);
   logic [DEPTH-1:0] vec_q;
   logic [DEPTH-1:0] shape;

   // bit i of the vector is the enable i+1 cycles after the command edge
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         shape[i] = ((i + 1) >= int'(lat)) && ((i + 1) < (int'(lat) + int'(len)));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else        vec_q <= {1'b0, vec_q[DEPTH-1:1]} | (fire ? shape : '0);
   end

   assign en   = vec_q[0];
   assign busy = |vec_q;

   // R1
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && lat == LAT_W'(1) && len != '0) |=> en);
   // R10
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && len == '0 && vec_q[DEPTH-1:1] == '0) |=> !en);
endmodule

// File: rtl/dfi_en_wfifo.sv
module dfi_en_wfifo #(
   parameter int WIDTH = 49,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [PTR_W:0]   cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (PTR_W+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + 1'b1;
         if (do_pop)  rp_q <= (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + 1'b1;
         cnt_q <= cnt_q + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/dfi_en_timer.sv
module dfi_en_timer
   import dfi_en_pkg::*;
#(
   parameter int DATA_W     = 36,
   parameter int MAX_LAT    = 16,
   parameter int MAX_LEN    = 16,
   parameter int FIFO_DEPTH = 16,
   parameter bit ECC_EN     = 1'b1,
   parameter int ECC_W      = 8,
   parameter int DEF_LAT    = 2,
   localparam int MASK_W    = (DATA_W + 7) / 8,
   localparam int LAT_W     = $clog2(MAX_LAT + 1),
   localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issue_i,
   input  logic [LEN_W-1:0]  rd_beats_i,
   input  logic              wr_issue_i,
   input  logic [LEN_W-1:0]  wr_beats_i,
   input  logic              wq_push_i,
   input  logic [DATA_W-1:0] wq_data_i,
   input  logic [MASK_W-1:0] wq_mask_i,
   input  logic [ECC_W-1:0]  wq_ecc_i,
   input  logic [LAT_W-1:0]  cfg_rd_lat_i,
   input  logic [LAT_W-1:0]  cfg_wr_lat_i,
   input  logic [LAT_W-1:0]  cfg_wd_lat_i,
   output logic              rddata_en_o,
   output logic              wrdata_en_o,
   output logic [DATA_W-1:0] wrdata_o,
   output logic [MASK_W-1:0] wrdata_mask_o,
   output logic              ecc_wrdata_en_o,
   output logic [ECC_W-1:0]  ecc_wrdata_o
);
   localparam int RD_DEPTH = MAX_LAT + MAX_LEN;
   localparam int WD_DEPTH = 2 * MAX_LAT + MAX_LEN;
   localparam int ENT_W    = DATA_W + MASK_W + ECC_W;

   if (MAX_LAT < 1) begin : g_bad_lat
      $error("MAX_LAT must be at least 1");
   end
   if (MAX_LEN < 1) begin : g_bad_len
      $error("MAX_LEN must be at least 1");
   end
   if ((FIFO_DEPTH < 2) || ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)) begin : g_bad_fifo
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (mask_bits(DATA_W) != MASK_W) begin : g_bad_mask
      $error("mask width mismatch");
   end
   if ((DEF_LAT < 1) || (DEF_LAT > MAX_LAT)) begin : g_bad_def
      $error("DEF_LAT out of range");
   end

   // ---------------- latency capture ----------------
   logic [LAT_W-1:0] rd_lat_q, wr_lat_q, wd_lat_q;
   logic [LAT_W:0]   wd_lat_sum;
   logic             rd_busy, wr_busy, wd_busy, idle;
   logic             rd_en, wr_en, wd_en;

   assign idle = !rd_busy && !wr_busy && !wd_busy && !rd_issue_i && !wr_issue_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_lat_q <= LAT_W'(DEF_LAT);
         wr_lat_q <= LAT_W'(DEF_LAT);
         wd_lat_q <= '0;
      end else if (idle) begin
         rd_lat_q <= LAT_W'(lat_clamp(int'(cfg_rd_lat_i), 1, MAX_LAT));
         wr_lat_q <= LAT_W'(lat_clamp(int'(cfg_wr_lat_i), 1, MAX_LAT));
         wd_lat_q <= LAT_W'(lat_clamp(int'(cfg_wd_lat_i), 0, MAX_LAT));
      end
   end

   assign wd_lat_sum = {1'b0, wr_lat_q} + {1'b0, wd_lat_q};

   // ---------------- enable windows ----------------
   dfi_en_window #(.DEPTH(RD_DEPTH), .LAT_W(LAT_W), .LEN_W(LEN_W)) u_rd_win (
      .clk(clk), .rst_n(rst_n), .fire(rd_issue_i), .lat(rd_lat_q),
      .len(rd_beats_i), .en(rd_en), .busy(rd_busy));

   dfi_en_window #(.DEPTH(RD_DEPTH), .LAT_W(LAT_W), .LEN_W(LEN_W)) u_wr_win (
      .clk(clk), .rst_n(rst_n), .fire(wr_issue_i), .lat(wr_lat_q),
      .len(wr_beats_i), .en(wr_en), .busy(wr_busy));

   dfi_en_window #(.DEPTH(WD_DEPTH), .LAT_W(LAT_W + 1), .LEN_W(LEN_W)) u_wd_win (
      .clk(clk), .rst_n(rst_n), .fire(wr_issue_i), .lat(wd_lat_sum),
      .len(wr_beats_i), .en(wd_en), .busy(wd_busy));

   assign rddata_en_o = rd_en;
   assign wrdata_en_o = wr_en;

   // ---------------- write word queue ----------------
   logic [ENT_W-1:0]  q_head;
   logic              q_empty, q_full;
   logic [DATA_W-1:0] h_data;
   logic [MASK_W-1:0] h_mask;
   logic [ECC_W-1:0]  h_ecc;

   dfi_en_wfifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_wq (
      .clk(clk), .rst_n(rst_n), .push(wq_push_i),
      .din({wq_data_i, wq_mask_i, wq_ecc_i}), .pop(wd_en),
      .dout(q_head), .empty(q_empty), .full(q_full));

   assign {h_data, h_mask, h_ecc} = q_head;
   assign wrdata_o      = wd_en ? h_data : '0;
   assign wrdata_mask_o = wd_en ? h_mask : '0;

   if (ECC_EN) begin : g_ecc
      assign ecc_wrdata_en_o = wr_en;
      assign ecc_wrdata_o    = wd_en ? h_ecc : '0;
   end else begin : g_no_ecc
      assign ecc_wrdata_en_o = 1'b0;
      assign ecc_wrdata_o    = '0;
   end

   // R9
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_busy || wr_busy) |=> $stable(rd_lat_q) && $stable(wr_lat_q));
   // R6
   zero_data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_lat_q == '0) |-> (wd_en == wr_en));
   // R5
   data_only_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_en && !q_full) |-> (wrdata_o == '0));
endmodule

// File: tb/sim_dfi_en_timer.sv
`timescale 1ns/1ps
module sim_dfi_en_timer;
   localparam int DATA_W = 36;
   localparam int MASK_W = 5;
   localparam int ECC_W  = 8;
   localparam int LAT_W  = 5;
   localparam int LEN_W  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_issue_i = 0, wr_issue_i = 0, wq_push_i = 0;
   logic [LEN_W-1:0]  rd_beats_i = '0, wr_beats_i = '0;
   logic [DATA_W-1:0] wq_data_i = '0;
   logic [MASK_W-1:0] wq_mask_i = '0;
   logic [ECC_W-1:0]  wq_ecc_i = '0;
   logic [LAT_W-1:0]  cfg_rd_lat_i = 5'd2, cfg_wr_lat_i = 5'd2, cfg_wd_lat_i = 5'd0;
   logic              rddata_en_o, wrdata_en_o, ecc_wrdata_en_o;
   logic [DATA_W-1:0] wrdata_o;
   logic [MASK_W-1:0] wrdata_mask_o;
   logic [ECC_W-1:0]  ecc_wrdata_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dfi_en_timer u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_issue_i(rd_issue_i), .rd_beats_i(rd_beats_i),
      .wr_issue_i(wr_issue_i), .wr_beats_i(wr_beats_i),
      .wq_push_i(wq_push_i), .wq_data_i(wq_data_i), .wq_mask_i(wq_mask_i), .wq_ecc_i(wq_ecc_i),
      .cfg_rd_lat_i(cfg_rd_lat_i), .cfg_wr_lat_i(cfg_wr_lat_i), .cfg_wd_lat_i(cfg_wd_lat_i),
      .rddata_en_o(rddata_en_o), .wrdata_en_o(wrdata_en_o),
      .wrdata_o(wrdata_o), .wrdata_mask_o(wrdata_mask_o),
      .ecc_wrdata_en_o(ecc_wrdata_en_o), .ecc_wrdata_o(ecc_wrdata_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] w_data(int seed, int i);
      return {4'(i), 32'(seed * 32'h01010101) ^ 32'(i * 32'h0f0f)};
   endfunction
   function automatic logic [MASK_W-1:0] w_mask(int seed, int i);
      return MASK_W'(seed + i * 3);
   endfunction
   function automatic logic [ECC_W-1:0] w_ecc(int seed, int i);
      return ECC_W'(seed * 5 + i);
   endfunction

   task automatic set_lat(input int r, input int w, input int d);
      cfg_rd_lat_i = LAT_W'(r);
      cfg_wr_lat_i = LAT_W'(w);
      cfg_wd_lat_i = LAT_W'(d);
      repeat (3) @(negedge clk);
   endtask

   task automatic push_words(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         wq_push_i = 1'b1;
         wq_data_i = w_data(seed, i);
         wq_mask_i = w_mask(seed, i);
         wq_ecc_i  = w_ecc(seed, i);
         @(negedge clk);
      end
      wq_push_i = 1'b0;
   endtask

   // R12
   task automatic t_reset();
      chk("R12 rd_en", 64'(rddata_en_o), 0);
      chk("R12 wr_en", 64'(wrdata_en_o), 0);
      chk("R12 data", 64'(wrdata_o), 0);
      chk("R12 mask", 64'(wrdata_mask_o), 0);
      chk("R12 ecc_en", 64'(ecc_wrdata_en_o), 0);
      chk("R12 ecc", 64'(ecc_wrdata_o), 0);
   endtask

   // R1 R2 (and R11 when prog differs from eff)
   task automatic t_read(input string req, input int prog, input int eff, input int len);
      set_lat(prog, 2, 0);
      rd_issue_i = 1'b1;
      rd_beats_i = LEN_W'(len);
      for (int k = 1; k <= eff + len + 3; k++) begin
         @(negedge clk);
         rd_issue_i = 1'b0;
         chk(req, 64'(rddata_en_o), 64'((k >= eff) && (k < eff + len)));
      end
   endtask

   // R3 R5 R6 R7 R8
   task automatic t_write(input string req, input int lw, input int wd, input int len, input int seed);
      set_lat(2, lw, wd);
      push_words(len, seed);
      wr_issue_i = 1'b1;
      wr_beats_i = LEN_W'(len);
      for (int k = 1; k <= lw + wd + len + 3; k++) begin
         int j;
         bit in_win;
         @(negedge clk);
         wr_issue_i = 1'b0;
         j = k - lw - wd;
         in_win = (j >= 0) && (j < len);
         chk({req, " R3 wr_en"}, 64'(wrdata_en_o), 64'((k >= lw) && (k < lw + len)));
         chk({req, " R8 ecc_en"}, 64'(ecc_wrdata_en_o), 64'((k >= lw) && (k < lw + len)));
         chk({req, " R5 data"}, 64'(wrdata_o), in_win ? 64'(w_data(seed, j)) : 64'd0);
         chk({req, " R7 mask"}, 64'(wrdata_mask_o), in_win ? 64'(w_mask(seed, j)) : 64'd0);
         chk({req, " R8 ecc"}, 64'(ecc_wrdata_o), in_win ? 64'(w_ecc(seed, j)) : 64'd0);
      end
   endtask

   // R4: two reads of 4 beats, issued 4 cycles apart, latency 2
   task automatic t_back_to_back();
      set_lat(2, 2, 0);
      rd_issue_i = 1'b1;
      rd_beats_i = LEN_W'(4);
      for (int k = 1; k <= 13; k++) begin
         @(negedge clk);
         chk("R4 merged", 64'(rddata_en_o), 64'((k >= 2) && (k < 10)));
         rd_issue_i = (k == 4);
      end
      rd_issue_i = 1'b0;
   endtask

   // R9: latency change while a burst is pending is ignored
   task automatic t_lat_change();
      set_lat(3, 2, 0);
      rd_issue_i = 1'b1;
      rd_beats_i = LEN_W'(4);
      for (int k = 1; k <= 14; k++) begin
         @(negedge clk);
         chk("R9 pending", 64'(rddata_en_o), 64'((k >= 3) && (k < 9)));
         if (k == 1) cfg_rd_lat_i = LAT_W'(6);
         rd_issue_i = (k == 4);
         if (k == 4) rd_beats_i = LEN_W'(2);
      end
      rd_issue_i = 1'b0;
      t_read("R9 after idle", 6, 6, 3);
   endtask

   // R10
   task automatic t_zero_len();
      set_lat(1, 1, 0);
      rd_issue_i = 1'b1;
      rd_beats_i = '0;
      wr_issue_i = 1'b1;
      wr_beats_i = '0;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         rd_issue_i = 1'b0;
         wr_issue_i = 1'b0;
         chk("R10 rd", 64'(rddata_en_o), 0);
         chk("R10 wr", 64'(wrdata_en_o), 0);
      end
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog R12 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      chk("R7 mask width", 64'($bits(wrdata_mask_o)), 64'd5);
      t_read("R1 R2 lat1", 1, 1, 3);
      t_read("R1 R2 lat5", 5, 5, 6);
      t_read("R11 lat0", 0, 1, 2);
      t_read("R11 lat_max", 31, 16, 2);
      t_write("R3 lw3 wd2", 3, 2, 4, 7);
      t_write("R6 wd0", 2, 0, 5, 3);
      t_write("R5 long", 4, 3, 8, 11);
      t_back_to_back();
      t_lat_change();
      t_zero_len();
      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule